// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Emulator

This block is a synthesizable stand-in for a byte-wide, one-time-programmable (or ultraviolet-erasable) memory. It is sized down for test: 1024 bytes by default instead of a full megabyte. It lets a larger design, or a programmer model, exercise the control protocol of such a part inside a clocked simulation or an FPGA prototype. Analog quantities are reduced to flags: the combined output-enable / programming-voltage pin becomes a two-bit level code, and the high voltage on the identifier address line becomes a single flag. Timing becomes clock cycles.

Each cycle the block decodes its control inputs into one of six modes: read, output disable, standby, program, program inhibit and identifier readout. Programming can only clear bits. Each program pulse stores the old byte ANDed with the data-bus byte, so a later verify read returns exactly what the cell kept. The only way back to all ones is an explicit erase-all input, which stands in for ultraviolet exposure.

The outgoing data bus is modelled as a registered value plus a drive-enable. When the enable is low the bus is high-impedance.

Top module: `otp_emu`

## Requirements
- R1: After reset the bus is released (`dq_oe` = 0) and every location reads 0xFF.
- R2: With `ce_n` = 0, `gvp_level` = 2'b00 (low) and `id_hv` = 0, the byte at the addressed location is driven with `dq_oe` = 1 one clock after the inputs are applied.
- R3: A program pulse stores (old byte AND `din`), so a 0 bit can never return to 1 by programming.
- R4: With `ce_n` = 1 and `gvp_level` not 2'b10, the bus is released one clock later, whatever the level code.
- R5: With `ce_n` = 0 and `gvp_level` = 2'b01 or 2'b11 (high), the bus is released one clock later.
- R6: While `gvp_level` = 2'b10 (programming voltage) the bus is released. With `ce_n` = 1 in that state nothing is written.
- R7: With programming voltage present, the falling edge of `ce_n` writes exactly once, using the address and data of that first low cycle. Later cycles of the same low pulse write nothing.
- R8: With `id_hv` = 1, `ce_n` = 0 and level low, and address bits above bit 0 all zero, the bus drives 0x20 for address bit 0 = 0 and 0x42 for bit 0 = 1. If any higher address bit is set, it drives 0x00.
- R9: `erase_all` = 1 sets every location to 0xFF in one cycle, but has no effect while `gvp_level` = 2'b10.
- R10: Address bits above the modelled depth are ignored: the location used is the address modulo the depth, for both reads and programming.
- R11: While the bus is released, `dq_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; restores the delivered (all ones) state |
| ce_n | input | 1 | Chip enable, active low; its falling edge is the program pulse |
| gvp_level | input | 2 | Combined enable/programming pin level: 00 low, 01 or 11 high, 10 programming voltage |
| id_hv | input | 1 | High voltage present on the identifier address line |
| addr | input | ADDR_W (20) | Byte address |
| din | input | DATA_W (8) | Byte to program |
| erase_all | input | 1 | Erase the whole array to 0xFF |
| dq_o | output | DATA_W (8) | Data bus value |
| dq_oe | output | 1 | Bus drive enable; 0 means high-impedance |

## Verification
The assertions take for granted that `gvp_level` only carries the four defined codes and that the inputs are stable across each rising clock edge. They also assume a program pulse is framed by `ce_n` being high in the cycle before it, so that a falling edge can be seen. The stimulus changes every input on the falling clock edge only. It always raises programming voltage one cycle before lowering `ce_n`, and raises `ce_n` again before dropping the voltage. Erase requests are issued both under programming voltage and without it, so that both outcomes are covered.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUTDIS,
        M_PROGRAM,
        M_INHIBIT,
        M_IDENT
    } mode_e;

    localparam logic [1:0] GV_LOW  = 2'b00;
    localparam logic [1:0] GV_HIGH = 2'b01;
    localparam logic [1:0] GV_PROG = 2'b10;

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic       ce_n,
    input  logic [1:0] gvp_level,
    input  logic       id_hv,
    output mode_e      mode
);

    always_comb begin
        if (gvp_level == GV_PROG) begin
            mode = ce_n ? M_INHIBIT : M_PROGRAM;
        end else if (ce_n) begin
            mode = M_STANDBY;
        end else if (gvp_level == GV_LOW) begin
            mode = id_hv ? M_IDENT : M_READ;
        end else begin
            mode = M_OUTDIS;
        end
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              ce_n,
    input  logic              vpp_on,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase_all,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    typedef struct packed {
        logic ce_n_prev;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic              pgm_fire;

    assign idx = addr[IDX_W-1:0];

    always_comb begin
        ctl_d.ce_n_prev = ce_n;
        mem_d           = mem_q;
        pgm_fire        = (mode == M_PROGRAM) && ctl_q.ce_n_prev;
        if (erase_all && !vpp_on) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = ERASED;
            end
        end else if (pgm_fire) begin
            mem_d[idx] = mem_q[idx] & din;
        end
        rd_data = mem_q[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.ce_n_prev <= 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= ERASED;
            end
        end else begin
            ctl_q <= ctl_d;
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/otp_bus_drv.sv
module otp_bus_drv
    import otp_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              ADDR_W   = 20,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] data;
    } drv_t;

    drv_t              drv_d, drv_q;
    logic [DATA_W-1:0] id_byte;
    logic              id_upper_zero;

    always_comb begin
        id_upper_zero = (addr[ADDR_W-1:1] == '0);
        id_byte       = id_upper_zero ? (addr[0] ? DEV_CODE : MFR_CODE) : '0;
        drv_d         = '0;
        case (mode)
            M_READ: begin
                drv_d.en   = 1'b1;
                drv_d.data = rd_data;
            end
            M_IDENT: begin
                drv_d.en   = 1'b1;
                drv_d.data = id_byte;
            end
            default: drv_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign dq_o  = drv_q.data;
    assign dq_oe = drv_q.en;

endmodule

// File: rtl/otp_emu.sv
module otp_emu
    import otp_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                DEPTH    = 1024,
    parameter int                ADDR_W   = 20,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [1:0]        gvp_level,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase_all,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    mode_e             mode;
    logic [DATA_W-1:0] rd_data;
    logic              vpp_on;

    assign vpp_on = (gvp_level == GV_PROG);

    otp_mode_dec u_dec (
        .ce_n      (ce_n),
        .gvp_level (gvp_level),
        .id_hv     (id_hv),
        .mode      (mode)
    );

    otp_cell_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ce_n      (ce_n),
        .vpp_on    (vpp_on),
        .addr      (addr),
        .din       (din),
        .erase_all (erase_all),
        .rd_data   (rd_data)
    );

    otp_bus_drv #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .addr    (addr),
        .rd_data (rd_data),
        .dq_o    (dq_o),
        .dq_oe   (dq_oe)
    );

endmodule

// File: rtl/otp_emu_chk.sv
module otp_emu_chk
    import otp_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 20,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h42
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic [1:0]        gvp_level,
    input logic              id_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe
);

    p_standby_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && gvp_level != GV_PROG) |=> !dq_oe);

    p_outdis_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && gvp_level[0]) |=> !dq_oe);

    p_prog_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gvp_level == GV_PROG) |=> !dq_oe);

    p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && gvp_level == GV_LOW) |=> dq_oe);

    p_ident_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && gvp_level == GV_LOW && id_hv && addr[ADDR_W-1:1] == '0)
        |=> (dq_o == ($past(addr[0]) ? DEV_CODE : MFR_CODE)));

    p_released_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_o == '0));

endmodule

bind otp_emu otp_emu_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .gvp_level (gvp_level),
    .id_hv     (id_hv),
    .addr      (addr),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe)
);

// File: tb/otp_emu_tb.sv
module otp_emu_tb_top;

    localparam logic [1:0] LV_LOW  = 2'b00;
    localparam logic [1:0] LV_HIGH = 2'b01;
    localparam logic [1:0] LV_PROG = 2'b10;
    localparam logic [1:0] LV_HI3  = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n;
    logic [1:0]  gvp_level;
    logic        id_hv;
    logic [19:0] addr;
    logic [7:0]  din;
    logic        erase_all;
    logic [7:0]  dq_o;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    otp_emu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .gvp_level (gvp_level),
        .id_hv     (id_hv),
        .addr      (addr),
        .din       (din),
        .erase_all (erase_all),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe)
    );

    // monitor: compare the registered bus just after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({dq_oe, dq_o} !== e) begin
                errors++;
                $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h",
                         t, dq_oe, dq_o, e[8], e[7:0]);
            end
        end
    end

    task automatic step(input logic c, input logic [1:0] g, input logic id,
                        input logic [19:0] a, input logic [7:0] d, input logic er,
                        input logic chk, input logic [8:0] exp, input string tag);
        @(negedge clk);
        ce_n = c; gvp_level = g; id_hv = id; addr = a; din = d; erase_all = er;
        if (chk) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        step(1'b1, LV_HIGH, 1'b0, 20'd0, 8'h00, 1'b0, 1'b0, 9'h000, "");
    endtask

    task automatic rd(input logic [19:0] a, input logic [7:0] exp, input string tag);
        step(1'b0, LV_LOW, 1'b0, a, 8'h00, 1'b0, 1'b1, {1'b1, exp}, tag);
        idle();
    endtask

    task automatic pulse(input logic [19:0] a, input logic [7:0] d);
        step(1'b1, LV_PROG, 1'b0, a, d, 1'b0, 1'b0, 9'h000, "");
        step(1'b0, LV_PROG, 1'b0, a, d, 1'b0, 1'b1, 9'h000, "R6 bus released while programming");
        step(1'b1, LV_PROG, 1'b0, a, d, 1'b0, 1'b0, 9'h000, "");
        idle();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; gvp_level = LV_HIGH; id_hv = 1'b0;
        addr = '0; din = '0; erase_all = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if ({dq_oe, dq_o} !== 9'h000) begin
            errors++;
            $display("FAIL R1 reset state: got %b/%h, expected 0/00", dq_oe, dq_o);
        end
        // R1: delivered state all ones
        rd(20'd0, 8'hFF, "R1 erased at reset");
        rd(20'd1023, 8'hFF, "R1 erased at reset top");
        // R2 / R3: program then clear more bits
        pulse(20'd3, 8'h5A);
        rd(20'd3, 8'h5A, "R2 read programmed byte");
        pulse(20'd3, 8'h0F);
        rd(20'd3, 8'h0A, "R3 AND with old byte");
        pulse(20'd3, 8'hFF);
        rd(20'd3, 8'h0A, "R3 ones cannot be restored");
        // R7: long pulse with data change mid-pulse
        step(1'b1, LV_PROG, 1'b0, 20'd7, 8'hF0, 1'b0, 1'b0, 9'h000, "");
        step(1'b0, LV_PROG, 1'b0, 20'd7, 8'hF0, 1'b0, 1'b0, 9'h000, "");
        step(1'b0, LV_PROG, 1'b0, 20'd7, 8'h0F, 1'b0, 1'b0, 9'h000, "");
        step(1'b0, LV_PROG, 1'b0, 20'd7, 8'h00, 1'b0, 1'b0, 9'h000, "");
        step(1'b1, LV_PROG, 1'b0, 20'd7, 8'h00, 1'b0, 1'b0, 9'h000, "");
        idle();
        rd(20'd7, 8'hF0, "R7 single write per pulse");
        // R6: inhibit with ce_n high
        step(1'b1, LV_PROG, 1'b0, 20'd3, 8'h00, 1'b0, 1'b1, 9'h000, "R6 inhibit released");
        step(1'b1, LV_PROG, 1'b0, 20'd3, 8'h00, 1'b0, 1'b0, 9'h000, "");
        idle();
        rd(20'd3, 8'h0A, "R6 inhibit writes nothing");
        // R4 / R5 / R11
        step(1'b1, LV_LOW, 1'b0, 20'd3, 8'h00, 1'b0, 1'b1, 9'h000, "R4 standby released");
        step(1'b0, LV_HIGH, 1'b0, 20'd3, 8'h00, 1'b0, 1'b1, 9'h000, "R5 output disable");
        step(1'b0, LV_HI3, 1'b0, 20'd3, 8'h00, 1'b0, 1'b1, 9'h000, "R11 code 11 released, data zero");
        idle();
        // R8: identifier readout
        step(1'b0, LV_LOW, 1'b1, 20'd0, 8'h00, 1'b0, 1'b1, 9'h120, "R8 maker code");
        step(1'b0, LV_LOW, 1'b1, 20'd1, 8'h00, 1'b0, 1'b1, 9'h142, "R8 device code");
        step(1'b0, LV_LOW, 1'b1, 20'd2, 8'h00, 1'b0, 1'b1, 9'h100, "R8 upper bit set");
        idle();
        // R10: wrap modulo depth
        rd(20'd1027, 8'h0A, "R10 aliased read");
        pulse(20'd2057, 8'h3C);
        rd(20'd9, 8'h3C, "R10 aliased program");
        // R9: erase ignored under programming voltage, then applied
        step(1'b1, LV_PROG, 1'b0, 20'd0, 8'h00, 1'b1, 1'b0, 9'h000, "");
        idle();
        rd(20'd3, 8'h0A, "R9 erase ignored under program voltage");
        step(1'b1, LV_HIGH, 1'b0, 20'd0, 8'h00, 1'b1, 1'b0, 9'h000, "");
        idle();
        rd(20'd3, 8'hFF, "R9 erase restores ones");
        rd(20'd7, 8'hFF, "R9 erase restores ones second");
        pulse(20'd7, 8'h81);
        rd(20'd7, 8'h81, "R3 program after erase");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule